// File: doc/BRIEF.md
# Roller-Table Video Address Generator

This block turns the horizontal and vertical counters of a display timing generator into memory read addresses for a 720 by 256 monochrome bitmap, and turns the returned bytes into a serial pixel stream. Every displayed line begins wherever an entry of a 256-entry line-pointer table says it does. The table is 512 bytes of ordinary memory, two bytes per line. A line consists of 90 bytes. The first byte sits at the line's start address and each later byte sits 8 bytes after the one before it, so eight consecutive lines can share one block of character cells byte by byte.

A 7-bit table select input places the table in the lower 128 KB of memory. A vertical offset input rotates which table entry feeds each visible line, and an inverse input complements the visible pixels. During each horizontal blank the block reads the two bytes of the next line's entry. Each pixel byte is then read one byte time (8 clocks) before it is shifted out. Memory is a synchronous read port: data appears on `mem_rdata_i` in the cycle after `mem_rd_o` is high.

Top module: `roller_vid_agen`

## Requirements
- R1: While reset is high and in the first cycle after it, `mem_rd_o`, `pix_valid_o` and `pix_out_o` are all 0.
- R2: In the cycle after `hcnt_i` equals 720, the block reads the low byte of a table entry. Its address is bank*16384 + slot*512 + 2*index, where bank is `tbl_sel_i[6:4]` and slot is `tbl_sel_i[3:0]`. In the cycle after that, it reads the high byte at that address plus 1.
- R3: The entry index for display line n is (n + `voffs_i`) mod 256. The entry fetched during the blank of line `V_TOTAL-1` serves line 0.
- R4: A table entry is little-endian (low byte at the even address). Its 16-bit value e gives a line start of e[15:13]*16384 + e[12:3]*16 + e[2:0].
- R5: Byte k (0 to 89) of a line is read from (start + 8k) mod 131072. Pixel p of the line is bit 7-(p mod 8) of byte p/8, so the MSB goes out first.
- R6: Pixel p of an active line appears on `pix_out_o` in the cycle in which `hcnt_i` equals p+1. `pix_valid_o` is high exactly for these cycles of lines below `V_ACTIVE`, and `pix_out_o` is 0 whenever `pix_valid_o` is 0.
- R7: When `inverse_i` is 1, every valid pixel is the complement of its memory bit.
- R8: The read for byte k≥1 is issued in the cycle after `hcnt_i` = 8k-8. The read for byte 0 of the next line is issued in the cycle after `hcnt_i` = `H_TOTAL`-8. No read is issued in the cycles after other `hcnt_i` values in the active part of a line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hcnt_i | input | HC_W | Pixel counter, 0 to H_TOTAL-1 |
| vcnt_i | input | VC_W | Line counter, 0 to V_TOTAL-1 |
| tbl_sel_i | input | 7 | Table location: [6:4] bank, [3:0] offset in 512-byte units |
| voffs_i | input | 8 | Vertical offset added to the line number to form the table index |
| inverse_i | input | 1 | Complement the visible pixels |
| mem_rdata_i | input | 8 | Read data, valid the cycle after mem_rd_o |
| mem_addr_o | output | 17 | Read byte address |
| mem_rd_o | output | 1 | Read strobe |
| pix_out_o | output | 1 | Serial pixel |
| pix_valid_o | output | 1 | Pixel is in the visible area |

## Verification
The first table holds consecutive entries that interleave eight lines per cell. Used with a zero offset, it shows whether the 8-byte stride and the 3-bit line-within-cell field are applied. The same table is then used with an offset of 250 and inversion switched on, which separates a correct mod-256 index wrap from a saturating or unwrapped one and checks that blank pixels stay dark. A directed frame places the table in the highest bank and slot and uses all-ones entries, so the byte address carries past 128 KB and must wrap. Frames with random table contents, table locations, offsets and inversion catch errors in field position and byte order that the regular patterns could hide.

// File: rtl/roller_vid_pkg.sv
package roller_vid_pkg;

  localparam int ADDR_W = 17;

  typedef enum logic [1:0] {
    RK_NONE,
    RK_TLO,
    RK_THI,
    RK_PIX
  } rd_kind_t;

  // entry layout: [15:13] 16 KB block, [12:3] offset/16, [2:0] line in cell
  function automatic logic [ADDR_W-1:0] entry_to_addr(input logic [15:0] e);
    return {e[15:13], e[12:3], 1'b0, e[2:0]};
  endfunction

endpackage

// File: rtl/roller_fetch_seq.sv
module roller_fetch_seq
  import roller_vid_pkg::*;
#(
  parameter int H_ACTIVE = 720,
  parameter int H_TOTAL  = 800,
  parameter int V_TOTAL  = 312,
  parameter int HC_W     = 10,
  parameter int VC_W     = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HC_W-1:0]   hcnt_i,
  input  logic [VC_W-1:0]   vcnt_i,
  input  logic [6:0]        tbl_sel_i,
  input  logic [7:0]        voffs_i,
  input  logic [7:0]        mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic [7:0]        byte_o
);

  localparam logic [HC_W-1:0] HA     = HC_W'(H_ACTIVE);
  localparam logic [HC_W-1:0] HA1    = HC_W'(H_ACTIVE + 1);
  localparam logic [HC_W-1:0] PRE    = HC_W'(H_TOTAL - 8);
  localparam logic [HC_W-1:0] LAST_K = HC_W'(H_ACTIVE - 8);
  localparam logic [VC_W-1:0] VLAST  = VC_W'(V_TOTAL - 1);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(8);

  logic [VC_W-1:0]   nxt_line;
  logic [7:0]        tbl_idx;
  logic [ADDR_W-1:0] addr_q, ptr_q, start_q;
  logic              rd_q;
  rd_kind_t          kind_q, kind_d;
  logic [7:0]        lo_q, byte_q;

  always_comb begin
    nxt_line = (vcnt_i == VLAST) ? '0 : vcnt_i + 1'b1;
    tbl_idx  = 8'(nxt_line) + voffs_i;
  end

  // read issue: table pair at start of blank, pixel bytes one byte time early
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q   <= 1'b0;
      kind_q <= RK_NONE;
      addr_q <= '0;
      ptr_q  <= '0;
    end else begin
      rd_q   <= 1'b0;
      kind_q <= RK_NONE;
      if (hcnt_i == HA) begin
        rd_q   <= 1'b1;
        kind_q <= RK_TLO;
        addr_q <= {tbl_sel_i[6:4], 1'b0, tbl_sel_i[3:0], tbl_idx, 1'b0};
      end else if (hcnt_i == HA1) begin
        rd_q   <= 1'b1;
        kind_q <= RK_THI;
        addr_q <= {addr_q[ADDR_W-1:1], 1'b1};
      end else if (hcnt_i == PRE) begin
        rd_q   <= 1'b1;
        kind_q <= RK_PIX;
        addr_q <= start_q;
        ptr_q  <= start_q + STRIDE;
      end else if (hcnt_i < LAST_K && hcnt_i[2:0] == 3'd0) begin
        rd_q   <= 1'b1;
        kind_q <= RK_PIX;
        addr_q <= ptr_q;
        ptr_q  <= ptr_q + STRIDE;
      end
    end
  end

  // capture returning data by kind, one cycle after the strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      kind_d  <= RK_NONE;
      lo_q    <= '0;
      start_q <= '0;
      byte_q  <= '0;
    end else begin
      kind_d <= kind_q;
      case (kind_d)
        RK_TLO:  lo_q    <= mem_rdata_i;
        RK_THI:  start_q <= entry_to_addr({mem_rdata_i, lo_q});
        RK_PIX:  byte_q  <= mem_rdata_i;
        default: ;
      endcase
    end
  end

  assign mem_addr_o = addr_q;
  assign mem_rd_o   = rd_q;
  assign byte_o     = byte_q;

  // R2: low-byte read is always followed by the high byte at the next address
  p_tbl_pair_r2: assert property (@(posedge clk) disable iff (rst)
    (kind_q == RK_TLO) |=> (rd_q && kind_q == RK_THI && addr_q == $past(addr_q) + 1));

  // R8: pixel reads only in the slots one byte time ahead
  p_pix_slot_r8: assert property (@(posedge clk) disable iff (rst)
    (kind_q == RK_PIX) |-> ($past(hcnt_i) == PRE || $past(hcnt_i[2:0]) == 3'd0));

endmodule

// File: rtl/roller_pix_shift.sv
module roller_pix_shift #(
  parameter int H_ACTIVE = 720,
  parameter int V_ACTIVE = 256,
  parameter int HC_W     = 10,
  parameter int VC_W     = 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [HC_W-1:0] hcnt_i,
  input  logic [VC_W-1:0] vcnt_i,
  input  logic            inverse_i,
  input  logic [7:0]      byte_i,
  output logic            pix_out_o,
  output logic            pix_valid_o
);

  localparam logic [HC_W-1:0] HA = HC_W'(H_ACTIVE);
  localparam logic [VC_W-1:0] VA = VC_W'(V_ACTIVE);

  logic       active;
  logic [7:0] sh_q;
  logic       pix_q, val_q;

  assign active = (hcnt_i < HA) && (vcnt_i < VA);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      pix_q <= 1'b0;
      val_q <= 1'b0;
    end else if (active) begin
      val_q <= 1'b1;
      if (hcnt_i[2:0] == 3'd0) begin
        pix_q <= byte_i[7] ^ inverse_i;
        sh_q  <= {byte_i[6:0], 1'b0};
      end else begin
        pix_q <= sh_q[7] ^ inverse_i;
        sh_q  <= {sh_q[6:0], 1'b0};
      end
    end else begin
      val_q <= 1'b0;
      pix_q <= 1'b0;
    end
  end

  assign pix_out_o   = pix_q;
  assign pix_valid_o = val_q;

  // R6: outside the visible area the output is dark, whatever inverse says
  p_blank_dark_r6: assert property (@(posedge clk) disable iff (rst)
    !pix_valid_o |-> !pix_out_o);

  // R6: the visible run ends right after the last active pixel position
  p_valid_end_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(pix_valid_o) |-> ($past(hcnt_i) == HA));

endmodule

// File: rtl/roller_vid_agen.sv
module roller_vid_agen
  import roller_vid_pkg::*;
#(
  parameter int BYTES_PER_LINE = 90,
  parameter int H_TOTAL        = 800,
  parameter int V_ACTIVE       = 256,
  parameter int V_TOTAL        = 312,
  parameter int HC_W           = $clog2(H_TOTAL),
  parameter int VC_W           = $clog2(V_TOTAL)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HC_W-1:0]   hcnt_i,
  input  logic [VC_W-1:0]   vcnt_i,
  input  logic [6:0]        tbl_sel_i,
  input  logic [7:0]        voffs_i,
  input  logic              inverse_i,
  input  logic [7:0]        mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              pix_out_o,
  output logic              pix_valid_o
);

  localparam int H_ACTIVE = BYTES_PER_LINE * 8;

  logic [7:0] cur_byte;

  roller_fetch_seq #(
    .H_ACTIVE (H_ACTIVE),
    .H_TOTAL  (H_TOTAL),
    .V_TOTAL  (V_TOTAL),
    .HC_W     (HC_W),
    .VC_W     (VC_W)
  ) u_fetch (
    .clk         (clk),
    .rst         (rst),
    .hcnt_i      (hcnt_i),
    .vcnt_i      (vcnt_i),
    .tbl_sel_i   (tbl_sel_i),
    .voffs_i     (voffs_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_addr_o  (mem_addr_o),
    .mem_rd_o    (mem_rd_o),
    .byte_o      (cur_byte)
  );

  roller_pix_shift #(
    .H_ACTIVE (H_ACTIVE),
    .V_ACTIVE (V_ACTIVE),
    .HC_W     (HC_W),
    .VC_W     (VC_W)
  ) u_shift (
    .clk         (clk),
    .rst         (rst),
    .hcnt_i      (hcnt_i),
    .vcnt_i      (vcnt_i),
    .inverse_i   (inverse_i),
    .byte_i      (cur_byte),
    .pix_out_o   (pix_out_o),
    .pix_valid_o (pix_valid_o)
  );

  // R1: the first cycle out of reset is quiet
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mem_rd_o && !pix_valid_o && !pix_out_o));

endmodule

// File: tb/roller_vid_agen_test.sv
module roller_vid_agen_test;

  localparam int BPL = 90;
  localparam int HA  = BPL * 8;
  localparam int HT  = 752;
  localparam int VA  = 12;
  localparam int VT  = 15;
  localparam int HW  = $clog2(HT);
  localparam int VW  = $clog2(VT);
  localparam int NFR = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [HW-1:0] hcnt = '0;
  logic [VW-1:0] vcnt = '0;
  logic [6:0]    tsel = '0;
  logic [7:0]    voffs = '0;
  logic          inv = 1'b0;
  logic [7:0]    rdata = '0;
  logic [16:0]   maddr;
  logic          mrd, pix, pval;

  logic [15:0] tbl [256];
  int  seed;
  int  n_cmp = 0;
  int  n_bad = 0;
  bit  fin = 1'b0;

  always #10 clk = ~clk;

  roller_vid_agen #(
    .BYTES_PER_LINE (BPL),
    .H_TOTAL        (HT),
    .V_ACTIVE       (VA),
    .V_TOTAL        (VT)
  ) uut (
    .clk         (clk),
    .rst         (rst),
    .hcnt_i      (hcnt),
    .vcnt_i      (vcnt),
    .tbl_sel_i   (tsel),
    .voffs_i     (voffs),
    .inverse_i   (inv),
    .mem_rdata_i (rdata),
    .mem_addr_o  (maddr),
    .mem_rd_o    (mrd),
    .pix_out_o   (pix),
    .pix_valid_o (pval)
  );

  function automatic int tbase();
    return int'(tsel[6:4]) * 16384 + int'(tsel[3:0]) * 512;
  endfunction

  function automatic int line_start(int ln);
    logic [15:0] e;
    e = tbl[(ln + int'(voffs)) % 256];
    return (int'(e[15:13]) * 16384 + int'(e[12:3]) * 16 + int'(e[2:0])) % 131072;
  endfunction

  function automatic logic [7:0] mem_byte(int a);
    int b;
    int o;
    logic [15:0] e;
    b = tbase();
    if (a >= b && a < b + 512) begin
      o = a - b;
      e = tbl[o / 2];
      return (o % 2 == 1) ? e[15:8] : e[7:0];
    end
    return 8'((a * 37) ^ (a >> 5) ^ seed);
  endfunction

  function automatic bit exp_pix(int ln, int p);
    int a;
    logic [7:0] d;
    a = (line_start(ln) + 8 * (p / 8)) % 131072;
    d = mem_byte(a);
    return d[7 - (p % 8)] ^ inv;
  endfunction

  // synchronous memory model: data the cycle after the strobe
  always @(posedge clk) if (mrd) rdata <= mem_byte(int'(maddr));

  task automatic check(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic setup(int f);
    seed = $urandom;
    case (f)
      0: begin
        tsel <= 7'h00; voffs <= 8'd0; inv <= 1'b0;
        for (int i = 0; i < 256; i++) tbl[i] = {3'd1, 10'((i / 8) * 45), 3'(i % 8)};
      end
      1: begin
        tsel <= 7'h12; voffs <= 8'd250; inv <= 1'b1;
      end
      2: begin
        tsel <= 7'h7F; voffs <= 8'd3; inv <= 1'b0;
        for (int i = 0; i < 256; i++) tbl[i] = (i % 2 == 1) ? 16'hFFFF : 16'($urandom);
      end
      default: begin
        tsel <= 7'($urandom); voffs <= 8'($urandom); inv <= 1'($urandom);
        for (int i = 0; i < 256; i++) tbl[i] = 16'($urandom);
      end
    endcase
  endtask

  always @(negedge clk) begin
    if (!rst && !fin) begin
      int h, v, ea, nx, k;
      bit eb;
      h = int'(hcnt);
      v = int'(vcnt);
      if (h >= 1 && h <= HA && v < VA) begin
        check(pval == 1'b1, "R6 valid", pval, 1);
        eb = exp_pix(v, h - 1);
        if (inv) check(pix == eb, "R7 inverted pixel", pix, eb);
        else     check(pix == eb, "R5 pixel", pix, eb);
      end else begin
        check(pval == 1'b0 && pix == 1'b0, "R6 blank dark", {pval, pix}, 0);
      end
      if (h == HA + 1 || h == HA + 2) begin
        nx = (v == VT - 1) ? 0 : v + 1;
        ea = tbase() + 2 * ((nx + int'(voffs)) % 256) + (h - HA - 1);
        check(mrd && int'(maddr) == ea, "R2 table read at R3 index", int'(maddr), ea);
      end
      if (v < VA && h % 8 == 1 && h <= HA - 15) begin
        k = (h + 7) / 8;
        ea = (line_start(v) + 8 * k) % 131072;
        check(mrd && int'(maddr) == ea, "R8 byte fetch stride", int'(maddr), ea);
      end
      if (h == HT - 7 && ((v + 1) % VT) < VA) begin
        ea = line_start((v + 1) % VT);
        check(mrd && int'(maddr) == ea, "R4 first byte from entry", int'(maddr), ea);
      end
      if (h % 8 == 4 && h < HA)
        check(!mrd, "R8 idle slot", mrd, 0);
    end
  end

  initial begin
    int f, h, v;
    seed = $urandom(20240611);
    setup(0);
    f = 1;
    vcnt = VW'(VT - 1);
    hcnt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!pval && !pix && !mrd, "R1 reset quiet", {pval, pix, mrd}, 0);
    @(posedge clk);
    rst <= 1'b0;
    h = 0;
    v = VT - 1;
    while (f <= NFR) begin
      @(posedge clk);
      h = h + 1;
      if (h == HT) begin
        h = 0;
        v = (v + 1) % VT;
      end
      hcnt <= HW'(h);
      vcnt <= VW'(v);
      if (v == VA && h == 0) begin
        if (f < NFR) setup(f);
        f++;
      end
    end
    @(negedge clk);
    if (!fin) begin
      fin = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 190000);
    if (!fin) begin
      fin = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule